// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the slave end of a three-wire control link. It accepts 16-bit write frames from a host and loads 9-bit values into a small register file. It can also return the contents of a few read-only identity and status registers on a separate data-out line. The serial inputs (chip select, serial clock, serial data) are synchronised into the system clock domain. Their edges are detected there, so all state lives in one clock domain. A write is committed only when chip select rises. The host may hold chip select low across the whole frame, or pulse it low only once all bits have been clocked in.

Readback is controlled by two bits in a control register. One bit enables the data-out driver. The other picks how the readback target is chosen:

- **Fixed pointer:** the target is set by writing a selection register.
- **Auto-advancing pointer:** the target moves forward by one after every committed frame.

The read value is shifted out most-significant bit first during the data half of any frame. The host therefore reads by sending frames to an unmapped address and sampling the data-out line on each rising serial clock edge.

A hardware-mode input turns the serial path off entirely for systems that strap the configuration on pins.

Top module: `ctrl_port3w`

## Requirements
- R1: After reset, every configuration register reads zero on `cfg_out` and `spi_sdo_oe` is low.
- R2: A frame carries a 7-bit address and then a 9-bit data word. The bits are shifted most-significant first (address bit 6 first, data bit 0 last), and each bit is sampled on a rising edge of `spi_sck`.
- R3: A frame changes no register until `spi_cs_n` rises, even after all 16 bits have been clocked in.
- R4: Both framing forms commit identically: chip select held low for the whole frame, or chip select high during the bits followed by a short low pulse.
- R5: A frame whose rising-edge count is not exactly 16 when chip select rises is discarded, and no register changes.
- R6: While `hw_mode` is high, serial traffic has no effect: no register is written and `spi_sdo_oe` stays low.
- R7: Addresses 0, 1 and 2 read back the fixed identity words 0x1A5, 0x0C3 and 0x027, and writes to them are ignored.
- R8: The control register at address 31 holds the readback enable in bit 0. While that bit is clear, `spi_sdo_oe` stays low.
- R9: In the data half of a frame with chip select low, the target register is shifted out on `spi_sdo` most-significant bit first, one bit per falling `spi_sck` edge. Data bit 8 is valid before the 8th rising edge. `spi_sdo_oe` is low while chip select is high.
- R10: Only the identity registers and the status registers can be read. The status registers sit at addresses 8 and 9 and mirror `status_in` slots 0 and 1. For any other target, `spi_sdo_oe` stays low.
- R11: Bit 1 of the control register selects the readback mode. With 0, the target changes only when address 30 is written (its low 7 data bits become the target). With 1, the target also advances by one after every committed frame not addressed to 30.
- R12: The configuration registers at addresses 16 to 23 are writable. Register 16+i appears on `cfg_out[9i+8:9i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_mode | input | 1 | High disables the serial path (pin-strapped control) |
| spi_cs_n | input | 1 | Serial chip select, active low; rising edge commits |
| spi_sck | input | 1 | Serial clock from host |
| spi_sdi | input | 1 | Serial data from host |
| status_in | input | NSTAT*9 | Live status words, slot i readable at address 8+i |
| cfg_out | output | NCFG*9 | Configuration register contents |
| spi_sdo | output | 1 | Serial readback data |
| spi_sdo_oe | output | 1 | Output enable for spi_sdo (low means high impedance) |

## Verification
The assertions assume the serial inputs are far slower than the system clock. Each level of `spi_sck`, `spi_cs_n` and `spi_sdi` must be held for several system cycles, so that every edge is seen exactly once after synchronisation. They also assume `spi_sdi` is settled before the rising serial edge that samples it.

The stimulus keeps to this. It uses half periods of eight system cycles and changes data only while the serial clock is low. It toggles `hw_mode` only between frames and waits for it to pass through the synchroniser before the next frame.

// File: rtl/ctrl3w_pkg.sv
package ctrl3w_pkg;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 9;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/ctrl3w_sync.sv
module ctrl3w_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/ctrl3w_frame.sv
module ctrl3w_frame
    import ctrl3w_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hw,
    input  logic  sck_rise,
    input  logic  cs_rise,
    input  logic  sdi,
    output logic  wr_en,
    output addr_t wr_addr,
    output word_t wr_data,
    output cnt_t  bit_cnt
);
    localparam cnt_t CNT_FULL = cnt_t'(FRAME_W);
    localparam cnt_t CNT_SAT  = cnt_t'(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        cnt_t               cnt;
    } frame_st_t;

    frame_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hw || cs_rise) begin
            st_d.cnt = '0;
        end else if (sck_rise) begin
            st_d.sh = {st_q.sh[FRAME_W-2:0], sdi};
            if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + cnt_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en   = cs_rise && !hw && (st_q.cnt == CNT_FULL);
    assign wr_addr = st_q.sh[FRAME_W-1:DATA_W];
    assign wr_data = st_q.sh[DATA_W-1:0];
    assign bit_cnt = st_q.cnt;

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_SAT);

    // R6
    hw_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw |=> (st_q.cnt == '0));
endmodule

// File: rtl/ctrl3w_regs.sv
module ctrl3w_regs
    import ctrl3w_pkg::*;
#(
    parameter int    NSTAT     = 2,
    parameter int    STAT_BASE = 8,
    parameter int    NCFG      = 8,
    parameter int    CFG_BASE  = 16,
    parameter int    SEL_ADDR  = 30,
    parameter int    CTRL_ADDR = 31,
    parameter word_t ID0       = 9'h1A5,
    parameter word_t ID1       = 9'h0C3,
    parameter word_t ID2       = 9'h027,
    parameter word_t CFG_RST   = 9'h000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  addr_t                   wr_addr,
    input  word_t                   wr_data,
    input  logic [NSTAT*DATA_W-1:0] status_in,
    output logic [NCFG*DATA_W-1:0]  cfg_out,
    output logic                    rd_en,
    output word_t                   rd_word,
    output logic                    rd_ok
);
    localparam int    NID = 3;
    localparam addr_t SEL = addr_t'(SEL_ADDR);
    localparam addr_t CTL = addr_t'(CTRL_ADDR);
    localparam logic [NID-1:0][DATA_W-1:0] ID_TAB = {ID2, ID1, ID0};

    typedef struct packed {
        logic [NCFG-1:0][DATA_W-1:0] cfg;
        logic [1:0]                  ctrl;
        addr_t                       ptr;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < NCFG; i++) begin
                if (wr_addr == addr_t'(CFG_BASE + i)) st_d.cfg[i] = wr_data;
            end
            if (wr_addr == CTL) st_d.ctrl = wr_data[1:0];
            if (wr_addr == SEL) st_d.ptr = wr_data[ADDR_W-1:0];
            else if (st_q.ctrl[1]) st_d.ptr = st_q.ptr + addr_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= {NCFG{CFG_RST}};
            st_q.ctrl <= '0;
            st_q.ptr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_word = '0;
        rd_ok   = 1'b0;
        for (int i = 0; i < NID; i++) begin
            if (st_q.ptr == addr_t'(i)) begin
                rd_word = ID_TAB[i];
                rd_ok   = 1'b1;
            end
        end
        for (int i = 0; i < NSTAT; i++) begin
            if (st_q.ptr == addr_t'(STAT_BASE + i)) begin
                rd_word = status_in[i*DATA_W +: DATA_W];
                rd_ok   = 1'b1;
            end
        end
    end

    assign cfg_out = st_q.cfg;
    assign rd_en   = st_q.ctrl[0];

    // R11
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl[1] && !(wr_en && wr_addr == SEL)) |=> $stable(st_q.ptr));

    // R12
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.cfg));
endmodule

// File: rtl/ctrl3w_sdo.sv
module ctrl3w_sdo
    import ctrl3w_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hw,
    input  logic  cs_s,
    input  logic  sck_fall,
    input  cnt_t  bit_cnt,
    input  logic  rd_en,
    input  word_t rd_word,
    input  logic  rd_ok,
    output logic  sdo,
    output logic  sdo_oe
);
    typedef struct packed {
        word_t sh;
        logic  oe;
    } sdo_st_t;

    sdo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hw || cs_s) begin
            st_d.oe = 1'b0;
        end else if (sck_fall) begin
            if (bit_cnt == cnt_t'(ADDR_W)) begin
                st_d.sh = rd_word;
                st_d.oe = rd_en && rd_ok;
            end else if (bit_cnt >= cnt_t'(FRAME_W)) begin
                st_d.oe = 1'b0;
            end else begin
                st_d.sh = {st_q.sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo    = st_q.oe & st_q.sh[DATA_W-1];
    assign sdo_oe = st_q.oe;

    // R9
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.oe) |-> (bit_cnt == cnt_t'(ADDR_W)));
endmodule

// File: rtl/ctrl_port3w.sv
module ctrl_port3w
    import ctrl3w_pkg::*;
#(
    parameter int    NSTAT     = 2,
    parameter int    STAT_BASE = 8,
    parameter int    NCFG      = 8,
    parameter int    CFG_BASE  = 16,
    parameter int    SEL_ADDR  = 30,
    parameter int    CTRL_ADDR = 31,
    parameter word_t ID0       = 9'h1A5,
    parameter word_t ID1       = 9'h0C3,
    parameter word_t ID2       = 9'h027,
    parameter word_t CFG_RST   = 9'h000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hw_mode,
    input  logic                    spi_cs_n,
    input  logic                    spi_sck,
    input  logic                    spi_sdi,
    input  logic [NSTAT*DATA_W-1:0] status_in,
    output logic [NCFG*DATA_W-1:0]  cfg_out,
    output logic                    spi_sdo,
    output logic                    spi_sdo_oe
);
    typedef struct packed {
        logic cs_p;
        logic sck_p;
    } edge_st_t;

    logic [3:0] sync_q;
    logic       hw_s, cs_s, sck_s, sdi_s;
    edge_st_t   edge_d, edge_q;
    logic       sck_rise, sck_fall, cs_rise;
    logic       wr_en;
    addr_t      wr_addr;
    word_t      wr_data;
    cnt_t       bit_cnt;
    logic       rd_en, rd_ok;
    word_t      rd_word;

    ctrl3w_sync #(.W(4), .STAGES(2), .RST_VAL(4'b0100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hw_mode, spi_cs_n, spi_sck, spi_sdi}),
        .q     (sync_q)
    );

    assign {hw_s, cs_s, sck_s, sdi_s} = sync_q;

    always_comb begin
        edge_d.cs_p  = cs_s;
        edge_d.sck_p = sck_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '{cs_p: 1'b1, sck_p: 1'b0};
        else        edge_q <= edge_d;
    end

    assign sck_rise = sck_s && !edge_q.sck_p;
    assign sck_fall = !sck_s && edge_q.sck_p;
    assign cs_rise  = cs_s && !edge_q.cs_p;

    ctrl3w_frame i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw       (hw_s),
        .sck_rise (sck_rise),
        .cs_rise  (cs_rise),
        .sdi      (sdi_s),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .bit_cnt  (bit_cnt)
    );

    ctrl3w_regs #(
        .NSTAT(NSTAT), .STAT_BASE(STAT_BASE), .NCFG(NCFG), .CFG_BASE(CFG_BASE),
        .SEL_ADDR(SEL_ADDR), .CTRL_ADDR(CTRL_ADDR),
        .ID0(ID0), .ID1(ID1), .ID2(ID2), .CFG_RST(CFG_RST)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .status_in (status_in),
        .cfg_out   (cfg_out),
        .rd_en     (rd_en),
        .rd_word   (rd_word),
        .rd_ok     (rd_ok)
    );

    ctrl3w_sdo i_sdo (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw       (hw_s),
        .cs_s     (cs_s),
        .sck_fall (sck_fall),
        .bit_cnt  (bit_cnt),
        .rd_en    (rd_en),
        .rd_word  (rd_word),
        .rd_ok    (rd_ok),
        .sdo      (spi_sdo),
        .sdo_oe   (spi_sdo_oe)
    );

    // R3
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6
    hw_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_s |=> !spi_sdo_oe);

    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sdo_oe |-> rd_en);
endmodule

// File: tb/test_ctrl_port3w.sv
module test_ctrl_port3w;
    localparam int NSTAT = 2;
    localparam int NCFG  = 8;
    localparam int DW    = 9;
    localparam int HALF  = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  hw = 1'b0;
    logic                  cs = 1'b1;
    logic                  sck = 1'b0;
    logic                  sdi = 1'b0;
    logic [NSTAT*DW-1:0]   stat = '0;
    logic [NCFG*DW-1:0]    cfg;
    logic                  sdo, sdo_oe;

    always #10 clk = ~clk;

    ctrl_port3w i_ctrl_port3w (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_mode    (hw),
        .spi_cs_n   (cs),
        .spi_sck    (sck),
        .spi_sdi    (sdi),
        .status_in  (stat),
        .cfg_out    (cfg),
        .spi_sdo    (sdo),
        .spi_sdo_oe (sdo_oe)
    );

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        string      req;
        logic       oe;
        logic [8:0] val;
    } item_t;

    item_t       exp_q[$];
    logic [10:0] act_q[$];
    logic [8:0]  cap_word;
    logic        cap_oe_any, cap_oe_all;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic logic [8:0] slot(int i);
        return cfg[i*DW +: DW];
    endfunction

    task automatic shift_bits(logic [6:0] a, logic [8:0] d, int nbits);
        logic [15:0] w;
        w = {a, d};
        cap_word   = '0;
        cap_oe_any = 1'b0;
        cap_oe_all = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            sck = 1'b0;
            sdi = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(HALF);
            @(negedge clk);
            if (i >= 7 && i <= 15) begin
                cap_word[15-i] = sdo;
                cap_oe_any = cap_oe_any | sdo_oe;
                cap_oe_all = cap_oe_all & sdo_oe;
            end
            sck = 1'b1;
            wait_clk(HALF);
        end
        @(negedge clk);
        sck = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic write_long(logic [6:0] a, logic [8:0] d, int nbits = 16);
        @(negedge clk);
        cs = 1'b0;
        wait_clk(HALF);
        shift_bits(a, d, nbits);
        @(negedge clk);
        cs = 1'b1;
        wait_clk(2*HALF);
    endtask

    task automatic write_short(logic [6:0] a, logic [8:0] d, int nbits = 16);
        shift_bits(a, d, nbits);
        @(negedge clk);
        cs = 1'b0;
        wait_clk(HALF);
        @(negedge clk);
        cs = 1'b1;
        wait_clk(2*HALF);
    endtask

    // driver: push the expected readback, then run a dummy frame
    task automatic read_chk(string req, logic oe, logic [8:0] val, bit short_f = 1'b0);
        item_t it;
        it.req = req;
        it.oe  = oe;
        it.val = val;
        exp_q.push_back(it);
        if (short_f) write_short(7'h7F, 9'h000);
        else         write_long(7'h7F, 9'h000);
        act_q.push_back({cap_oe_any, cap_oe_all, cap_word});
    endtask

    // monitor: pop and compare captured readback against expectations
    always @(negedge clk) begin
        item_t       e;
        logic [10:0] a;
        if (exp_q.size() > 0 && act_q.size() > 0) begin
            e = exp_q.pop_front();
            a = act_q.pop_front();
            if (e.oe) begin
                check({e.req, " oe"}, int'(a[9]), 1);
                check({e.req, " data"}, int'(a[8:0]), int'(e.val));
            end else begin
                check({e.req, " oe"}, int'(a[10]), 0);
            end
        end
    end

    initial begin
        wait_clk(150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        wait_clk(3);
        @(negedge clk);
        rst_n = 1'b1;
        wait_clk(4);
        @(negedge clk);

        // R1 reset state
        check("R1 cfg", int'(cfg == '0), 1);
        check("R1 oe", int'(sdo_oe), 0);

        // R2 / R12 long frame, asymmetric pattern exposes bit order
        write_long(7'd16, 9'h15A);
        check("R2 R12 slot0", int'(slot(0)), 'h15A);

        // R3 no commit before chip select rises
        @(negedge clk);
        cs = 1'b0;
        wait_clk(HALF);
        shift_bits(7'd17, 9'h0AA, 16);
        wait_clk(4 * HALF);
        check("R3 before rise", int'(slot(1)), 0);
        @(negedge clk);
        cs = 1'b1;
        wait_clk(2 * HALF);
        check("R3 after rise", int'(slot(1)), 'h0AA);

        // R4 short chip select pulse form
        write_short(7'd18, 9'h1F0);
        check("R4 short form", int'(slot(2)), 'h1F0);

        // R5 wrong bit counts
        write_long(7'd19, 9'h133, 15);
        check("R5 15 bits", int'(slot(3)), 0);
        write_long(7'd19, 9'h133, 17);
        check("R5 17 bits", int'(slot(3)), 0);
        write_long(7'd19, 9'h101);
        check("R5 recovery", int'(slot(3)), 'h101);

        // R6 hardware mode ignores writes
        @(negedge clk);
        hw = 1'b1;
        wait_clk(6);
        write_long(7'd20, 9'h1AB);
        check("R6 write ignored", int'(slot(4)), 0);
        @(negedge clk);
        hw = 1'b0;
        wait_clk(6);

        // R8 readback disabled
        write_long(7'd30, 9'h000);
        read_chk("R8 disabled", 1'b0, 9'h000);

        // R7 / R9 identity readback
        write_long(7'd31, 9'h001);
        read_chk("R7 R9 id0", 1'b1, 9'h1A5);
        write_long(7'd0, 9'h000);
        read_chk("R7 id0 write ignored", 1'b1, 9'h1A5);
        write_long(7'd2, 9'h000);
        write_long(7'd30, 9'h002);
        read_chk("R7 id2", 1'b1, 9'h027);
        write_long(7'd30, 9'h001);
        read_chk("R7 id1", 1'b1, 9'h0C3);

        // R10 status and unreadable targets
        stat = {9'h0E1, 9'h13C};
        write_long(7'd30, 9'h008);
        read_chk("R10 status0", 1'b1, 9'h13C);
        write_long(7'd30, 9'h009);
        read_chk("R10 status1", 1'b1, 9'h0E1);
        write_long(7'd30, 9'd16);
        read_chk("R10 cfg unreadable", 1'b0, 9'h000);

        // R11 auto-advancing pointer
        write_long(7'd31, 9'h003);
        write_long(7'd30, 9'h000);
        read_chk("R11 adv 0", 1'b1, 9'h1A5);
        read_chk("R11 adv 1", 1'b1, 9'h0C3);
        read_chk("R11 adv 2", 1'b1, 9'h027);

        // R11 fixed pointer holds
        write_long(7'd31, 9'h001);
        write_long(7'd30, 9'h008);
        read_chk("R11 fixed a", 1'b1, 9'h13C);
        read_chk("R11 fixed b", 1'b1, 9'h13C);

        // R9 chip select high keeps the driver off
        read_chk("R9 cs high", 1'b0, 9'h000, 1'b1);

        // R6 hardware mode blocks readback
        @(negedge clk);
        hw = 1'b1;
        wait_clk(6);
        read_chk("R6 read blocked", 1'b0, 9'h000);
        @(negedge clk);
        hw = 1'b0;
        wait_clk(6);

        // R12 other slots untouched and last slot writable
        write_long(7'd23, 9'h0F7);
        check("R12 slot7", int'(slot(7)), 'h0F7);
        check("R12 slot5", int'(slot(5)), 0);

        wait_clk(8);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule